// File: doc/BRIEF.md
# Vectored Interrupt Controller with Daisy-Chained Acknowledge

This block gathers interrupt events from eight receive channels and three transmit channels and presents them to a processor as two independent request lines, one per group. Each event sets a sticky pending flag for its channel. A per-channel enable mask decides whether a pending flag takes part in the group request and in the selection of the channel that is serviced.

When the processor runs an acknowledge cycle for a group, it pulses that group's acknowledge input for one clock. If an enabled request is pending, the block answers on the next clock with a vector strobe. The vector carries the group's programmable base in its upper bits and the serviced channel number in its low bits, and the serviced flag is cleared. If nothing enabled is pending, the block drives the group's acknowledge output for one clock instead. A device further down the chain can then answer. Among the transmit channels, channel 0 always wins. Among the receive channels, the winner is the first enabled pending channel found when scanning upward from a programmable starting channel, wrapping around after channel 7.

Configuration is written through a small write port with a 3-bit register select.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset the following are all zero: every pending flag, both masks, both vector bases, the receive starting channel, both request lines, both vector strobes, both vectors and both acknowledge outputs.
- R2: A pulse on `rx_evt[i]` sets receive pending flag i at the next clock edge. `rx_irq` is the OR of the receive pending flags whose mask bit is 1.
- R3: A pulse on `tx_evt[i]` sets transmit pending flag i at the next clock edge. `tx_irq` is the OR of the enabled transmit pending flags. The two groups never affect each other.
- R4: If an acknowledge pulse arrives while an enabled request is pending in that group, the next cycle shows a one-cycle vector strobe. The acknowledge output stays 0 in that cycle. Between deliveries the vector output holds its last value.
- R5: If an acknowledge pulse arrives while no enabled request is pending in that group, the next cycle shows a one-cycle acknowledge output pulse with the vector strobe at 0.
- R6: A delivery clears only the serviced channel's pending flag. An event on that same channel in the acknowledge cycle leaves the flag set.
- R7: The serviced receive channel is the first enabled pending channel in the order s, s+1, ..., 7, 0, ..., s-1, where s is the programmed starting channel.
- R8: Transmit selection is fixed: channel 0 beats channel 1, and channel 1 beats channel 2.
- R9: A configuration write (`cfg_we`=1) selects a register with `cfg_addr`. Value 0 is the receive base (8 bits). Value 1 is the transmit base (8 bits). Value 2 is the receive mask (bit i enables channel i). Value 3 is the transmit mask (bits 2:0). Value 4 is the receive starting channel (bits 2:0). Values 5 to 7 change nothing.
- R10: A pending flag whose mask bit is 0 is kept. It raises the request after its mask bit is set.
- R11: The receive vector is {base[7:3], channel[2:0]}. The transmit vector is {base[7:2], channel[1:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt | input | 8 | Receive channel event pulses |
| tx_evt | input | 3 | Transmit channel event pulses |
| rx_iack_in | input | 1 | Receive group acknowledge strobe from upstream |
| tx_iack_in | input | 1 | Transmit group acknowledge strobe from upstream |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rx_irq | output | 1 | Receive group request |
| tx_irq | output | 1 | Transmit group request |
| rx_vec | output | 8 | Receive vector |
| rx_vec_vld | output | 1 | Receive vector strobe |
| rx_iack_out | output | 1 | Receive acknowledge passed downstream |
| tx_vec | output | 8 | Transmit vector |
| tx_vec_vld | output | 1 | Transmit vector strobe |
| tx_iack_out | output | 1 | Transmit acknowledge passed downstream |

## Verification
Directed sequences post several receive events under three starting channels and drain them with acknowledges. This shows whether the delivery order follows the wrap-around scan or a fixed order. A transmit burst on all three channels exposes any departure from the fixed order. Acknowledges against an empty, fully masked or half-masked group separate a correct pass-through from a false vector. An event that lands on the serviced channel in its acknowledge cycle tests set-over-clear precedence. A long run of random events, acknowledges and configuration writes, including the unused register selects, is compared against a behavioural model on every clock.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int RX_CH   = 8;
    localparam int TX_CH   = 3;
    localparam int VEC_W   = 8;
    localparam int CFG_AW  = 3;
    localparam int RX_IW   = $clog2(RX_CH);
    localparam int TX_IW   = $clog2(TX_CH);

    typedef enum logic [CFG_AW-1:0] {
        SEL_RX_BASE  = 3'd0,
        SEL_TX_BASE  = 3'd1,
        SEL_RX_MASK  = 3'd2,
        SEL_TX_MASK  = 3'd3,
        SEL_RX_START = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic             vld;
        logic             pass;
        logic [VEC_W-1:0] vec;
    } ack_resp_t;

    function automatic int ring_pos(input int start, input int step, input int n);
        return (start + step) % n;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | set;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> pend[i]);
        assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !pend[i]);
        assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && !set[i]) |=> $stable(pend[i]));
    end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          hit,
    output logic [IW-1:0] idx
);
    import irq_vec_pkg::*;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = ring_pos(int'(start), k, N);
            if (!hit && req[c]) begin
                hit = 1'b1;
                idx = IW'(c);
            end
        end
    end

endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          iack_in,
    input  logic                          req_any,
    input  logic [IW-1:0]                 sel_idx,
    input  logic [irq_vec_pkg::VEC_W-1:0] base,
    output logic [N-1:0]                  clr,
    output logic [irq_vec_pkg::VEC_W-1:0] vec,
    output logic                          vec_vld,
    output logic                          iack_out
);
    import irq_vec_pkg::*;

    ack_resp_t        resp;
    logic [VEC_W-1:0] vec_next;
    logic             deliver;

    assign deliver = iack_in && req_any;

    always_comb begin
        clr = '0;
        if (deliver) clr[sel_idx] = 1'b1;
        vec_next = base;
        vec_next[IW-1:0] = sel_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp.vld  <= deliver;
            resp.pass <= iack_in && !req_any;
            if (deliver) resp.vec <= vec_next;
        end
    end

    assign vec      = resp.vec;
    assign vec_vld  = resp.vld;
    assign iack_out = resp.pass;

    assert_deliver_R4: assert property (@(posedge clk) disable iff (rst)
        (iack_in && req_any) |=> (vec_vld && !iack_out));
    assert_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (iack_in && !req_any) |=> (iack_out && !vec_vld));
    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !iack_in |=> (!iack_out && !vec_vld));
    assert_one_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));
    assert_vec_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !iack_in |=> $stable(vec));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RX_CH-1:0]  rx_evt,
    input  logic [TX_CH-1:0]  tx_evt,
    input  logic              rx_iack_in,
    input  logic              tx_iack_in,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [VEC_W-1:0]  cfg_wdata,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic [VEC_W-1:0]  rx_vec,
    output logic              rx_vec_vld,
    output logic              rx_iack_out,
    output logic [VEC_W-1:0]  tx_vec,
    output logic              tx_vec_vld,
    output logic              tx_iack_out
);

    logic [VEC_W-1:0] rx_base, tx_base;
    logic [RX_CH-1:0] rx_mask, rx_pend, rx_req, rx_clr;
    logic [TX_CH-1:0] tx_mask, tx_pend, tx_req, tx_clr;
    logic [RX_IW-1:0] rx_start, rx_idx;
    logic [TX_IW-1:0] tx_idx;
    logic             rx_hit, tx_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_base  <= '0;
            tx_base  <= '0;
            rx_mask  <= '0;
            tx_mask  <= '0;
            rx_start <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                SEL_RX_BASE:  rx_base  <= cfg_wdata;
                SEL_TX_BASE:  tx_base  <= cfg_wdata;
                SEL_RX_MASK:  rx_mask  <= cfg_wdata[RX_CH-1:0];
                SEL_TX_MASK:  tx_mask  <= cfg_wdata[TX_CH-1:0];
                SEL_RX_START: rx_start <= cfg_wdata[RX_IW-1:0];
                default: ;
            endcase
        end
    end

    irq_pend_bank #(.N(RX_CH)) u_rx_pend (
        .clk(clk), .rst(rst), .set(rx_evt), .clr(rx_clr), .pend(rx_pend)
    );
    irq_pend_bank #(.N(TX_CH)) u_tx_pend (
        .clk(clk), .rst(rst), .set(tx_evt), .clr(tx_clr), .pend(tx_pend)
    );

    assign rx_req = rx_pend & rx_mask;
    assign tx_req = tx_pend & tx_mask;
    assign rx_irq = |rx_req;
    assign tx_irq = |tx_req;

    irq_prio_sel #(.N(RX_CH), .IW(RX_IW)) u_rx_sel (
        .req(rx_req), .start(rx_start), .hit(rx_hit), .idx(rx_idx)
    );
    irq_prio_sel #(.N(TX_CH), .IW(TX_IW)) u_tx_sel (
        .req(tx_req), .start('0), .hit(tx_hit), .idx(tx_idx)
    );

    irq_ack_unit #(.N(RX_CH), .IW(RX_IW)) u_rx_ack (
        .clk(clk), .rst(rst), .iack_in(rx_iack_in), .req_any(rx_hit),
        .sel_idx(rx_idx), .base(rx_base), .clr(rx_clr),
        .vec(rx_vec), .vec_vld(rx_vec_vld), .iack_out(rx_iack_out)
    );
    irq_ack_unit #(.N(TX_CH), .IW(TX_IW)) u_tx_ack (
        .clk(clk), .rst(rst), .iack_in(tx_iack_in), .req_any(tx_hit),
        .sel_idx(tx_idx), .base(tx_base), .clr(tx_clr),
        .vec(tx_vec), .vec_vld(tx_vec_vld), .iack_out(tx_iack_out)
    );

    assert_rx_sel_valid_R7: assert property (@(posedge clk) disable iff (rst)
        rx_hit |-> rx_req[rx_idx]);
    assert_rx_start_first_R7: assert property (@(posedge clk) disable iff (rst)
        rx_req[rx_start] |-> (rx_idx == rx_start));
    assert_tx_ch0_first_R8: assert property (@(posedge clk) disable iff (rst)
        tx_req[0] |-> (tx_idx == '0));
    assert_hit_iff_irq_R2: assert property (@(posedge clk) disable iff (rst)
        rx_hit == rx_irq);
    assert_tx_hit_iff_irq_R3: assert property (@(posedge clk) disable iff (rst)
        tx_hit == tx_irq);

endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] rx_evt;
    logic [2:0] tx_evt;
    logic       rx_iack_in, tx_iack_in, cfg_we;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       rx_irq, tx_irq, rx_vec_vld, rx_iack_out, tx_vec_vld, tx_iack_out;
    logic [7:0] rx_vec, tx_vec;

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst(rst), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .rx_iack_in(rx_iack_in), .tx_iack_in(tx_iack_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_irq(rx_irq), .tx_irq(tx_irq),
        .rx_vec(rx_vec), .rx_vec_vld(rx_vec_vld), .rx_iack_out(rx_iack_out),
        .tx_vec(tx_vec), .tx_vec_vld(tx_vec_vld), .tx_iack_out(tx_iack_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string tag = "R1";

    // behavioural model state
    bit [7:0] m_rx_pend, m_rx_mask, m_rx_base, m_rx_vec;
    bit [2:0] m_tx_pend, m_tx_mask;
    bit [7:0] m_tx_base, m_tx_vec;
    int       m_start;
    bit       m_rx_vld, m_rx_pass, m_tx_vld, m_tx_pass;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit e_rx_irq, e_tx_irq;
        e_rx_irq = (m_rx_pend & m_rx_mask) != 0;
        e_tx_irq = (m_tx_pend & m_tx_mask) != 0;
        check(rx_irq == e_rx_irq, "rx_irq", rx_irq, e_rx_irq);
        check(tx_irq == e_tx_irq, "tx_irq", tx_irq, e_tx_irq);
        check(rx_vec_vld == m_rx_vld, "rx_vec_vld", rx_vec_vld, m_rx_vld);
        check(rx_iack_out == m_rx_pass, "rx_iack_out", rx_iack_out, m_rx_pass);
        check(rx_vec == m_rx_vec, "rx_vec", rx_vec, m_rx_vec);
        check(tx_vec_vld == m_tx_vld, "tx_vec_vld", tx_vec_vld, m_tx_vld);
        check(tx_iack_out == m_tx_pass, "tx_iack_out", tx_iack_out, m_tx_pass);
        check(tx_vec == m_tx_vec, "tx_vec", tx_vec, m_tx_vec);
    endtask

    task automatic model_reset();
        m_rx_pend = 0; m_rx_mask = 0; m_rx_base = 0; m_rx_vec = 0;
        m_tx_pend = 0; m_tx_mask = 0; m_tx_base = 0; m_tx_vec = 0;
        m_start = 0;
        m_rx_vld = 0; m_rx_pass = 0; m_tx_vld = 0; m_tx_pass = 0;
    endtask

    // one clock: compare current outputs, drive inputs, advance the model
    task automatic cyc(input bit [7:0] rxe, input bit [2:0] txe, input bit rxa,
                       input bit txa, input bit we, input bit [2:0] a, input bit [7:0] d);
        int rsel, tsel;
        @(negedge clk);
        compare_all();
        rx_evt = rxe; tx_evt = txe; rx_iack_in = rxa; tx_iack_in = txa;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        rsel = -1;
        for (int k = 0; k < 8; k++) begin
            int c = (m_start + k) % 8;
            if (rsel < 0 && m_rx_pend[c] && m_rx_mask[c]) rsel = c;
        end
        tsel = -1;
        for (int k = 0; k < 3; k++)
            if (tsel < 0 && m_tx_pend[k] && m_tx_mask[k]) tsel = k;
        m_rx_vld = rxa && rsel >= 0;
        m_rx_pass = rxa && rsel < 0;
        if (m_rx_vld) begin
            m_rx_vec = (m_rx_base & 8'hF8) | 8'(rsel);
            m_rx_pend[rsel] = 1'b0;
        end
        m_tx_vld = txa && tsel >= 0;
        m_tx_pass = txa && tsel < 0;
        if (m_tx_vld) begin
            m_tx_vec = (m_tx_base & 8'hFC) | 8'(tsel);
            m_tx_pend[tsel] = 1'b0;
        end
        m_rx_pend |= rxe;
        m_tx_pend |= txe;
        if (we) begin
            case (a)
                3'd0: m_rx_base = d;
                3'd1: m_tx_base = d;
                3'd2: m_rx_mask = d;
                3'd3: m_tx_mask = d[2:0];
                3'd4: m_start = int'(d[2:0]);
                default: ;
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        cyc(0, 0, 0, 0, 1, a, d);
    endtask

    task automatic rx_ack_n(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 1, 0, 0, 0, 0);
            idle(1);
        end
    endtask

    initial begin
        rst = 1'b1;
        rx_evt = 0; tx_evt = 0; rx_iack_in = 0; tx_iack_in = 0;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        tag = "R1";                                  // reset state
        idle(2);

        tag = "R5";                                  // acknowledge with nothing pending passes on
        cyc(0, 0, 1, 1, 0, 0, 0);
        idle(2);

        tag = "R10";                                 // masked pending held, no request
        cyc(8'h08, 3'b010, 0, 0, 0, 0, 0);
        idle(1);
        cyc(0, 0, 1, 1, 0, 0, 0);                    // masked: pass-through
        idle(1);

        tag = "R9";                                  // configuration writes
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h07);
        wr(3'd0, 8'hA5);
        wr(3'd1, 8'h3E);
        idle(1);

        tag = "R11";                                 // vector format: ch3 -> A3, tx ch1 -> 3D
        cyc(0, 0, 1, 1, 0, 0, 0);
        idle(2);

        tag = "R7";                                  // wrap-around scan from three starts
        cyc(8'h62, 0, 0, 0, 0, 0, 0);
        rx_ack_n(4);
        wr(3'd4, 8'd6);
        cyc(8'h62, 0, 0, 0, 0, 0, 0);
        rx_ack_n(4);
        wr(3'd4, 8'd2);
        cyc(8'h62, 0, 0, 0, 0, 0, 0);
        rx_ack_n(4);

        tag = "R8";                                  // fixed transmit order
        cyc(0, 3'b111, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 0, 1, 0, 0, 0);
            idle(1);
        end

        tag = "R6";                                  // new event on serviced channel in ack cycle
        wr(3'd4, 8'd0);
        cyc(8'h01, 0, 0, 0, 0, 0, 0);
        cyc(8'h01, 0, 1, 0, 0, 0, 0);
        idle(1);
        rx_ack_n(2);

        tag = "R3";                                  // both groups at once, independent
        cyc(8'h10, 3'b100, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        idle(2);

        tag = "R2";                                  // partial mask, unused register selects
        wr(3'd2, 8'h0F);
        wr(3'd5, 8'h00);
        wr(3'd7, 8'h00);
        cyc(8'hF0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        idle(1);
        tag = "R10";
        wr(3'd2, 8'hF0);
        rx_ack_n(5);

        tag = "R4";                                  // random traffic
        for (int i = 0; i < 3000; i++) begin
            bit [7:0] re;
            bit [2:0] te;
            bit       ra, ta, we;
            re = 8'($urandom) & 8'($urandom) & 8'($urandom);
            te = 3'($urandom) & 3'($urandom);
            ra = ($urandom % 4) == 0;
            ta = ($urandom % 4) == 0;
            we = ($urandom % 16) == 0;
            cyc(re, te, ra, ta, we, 3'($urandom), 8'($urandom));
        end
        idle(2);

        @(negedge clk);
        compare_all();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule